// File: doc/BRIEF.md
# Dual-Port Out-of-Order Issue Queue

This block holds up to four decoded general-purpose instructions waiting for execution. Entry 0 is the oldest and sits at the bottom. Each entry records a tag, a unit class and an operands-ready flag. A dispatch stage appends up to two instructions per cycle above the entries already held. Only the two bottom entries compete for the execution ports. Each of those two entries has a fixed set of ports it can reach.

Entry 0 can reach simple unit A, the multiply/divide unit and the load/store unit. Entry 1 can reach simple unit B, the multiply/divide unit and the load/store unit. Simple unit B runs only the light subset of simple operations. Because of that, entry 1 may issue before entry 0 when the oldest instruction is stalled. After each issue, the remaining entries slide down and keep their age order. Readiness is raised through a wake port that matches on tag. A flush empties the queue.

The issue outputs are combinational from the held entries and the busy inputs. The capacity output tells the dispatch stage how many instructions it may send this cycle.

Top module: `gpr_issue_queue`

## Requirements
- R1: After reset the queue is empty, every issue valid output is low and `free_slots` is 2.
- R2: Write lane 0 is accepted before lane 1 and is treated as older. Accepted instructions become eligible for issue in the following cycle.
- R3: Entry 0, when ready, issues a class-0 (full simple) or class-1 (light simple) instruction to simple unit A, a class-2 instruction to the multiply/divide unit and a class-3 instruction to the load/store unit.
- R4: Entry 1, when ready, issues class 1 to simple unit B, class 2 to the multiply/divide unit and class 3 to the load/store unit. A class-0 instruction never issues from entry 1.
- R5: An entry issues only when it is valid, its ready flag is set and its target unit's busy input is low. Entries 2 and 3 never issue.
- R6: Entry 1 issues to simple unit B or the load/store unit even while entry 0 is held back by a busy multiply/divide unit.
- R7: When entries 0 and 1 both target the multiply/divide unit or both target the load/store unit, only entry 0 issues that cycle.
- R8: Entries that did not issue move down to the lowest positions and keep their relative order. New entries are placed above them.
- R9: `free_slots` equals the number of empty entries left after this cycle's issues, capped at 2. Write lanes beyond that count are dropped.
- R10: A wake request sets the ready flag of every held entry whose tag matches, and of any incoming lane whose tag matches. The effect appears in the next cycle.
- R11: While `flush` is high, all issue outputs are low and writes are dropped. In the next cycle the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue, suppress issue |
| in_valid | input | 2 | Write request per lane |
| in_tag | input | 2x6 | Tag per lane |
| in_cls | input | 2x2 | Unit class per lane (0 full simple, 1 light simple, 2 mul/div, 3 load/store) |
| in_rdy | input | 2 | Operands-ready flag per lane |
| wake_valid | input | 1 | Wake request |
| wake_tag | input | 6 | Tag to mark ready |
| busy_sa | input | 1 | Simple unit A busy |
| busy_sb | input | 1 | Simple unit B busy |
| busy_md | input | 1 | Multiply/divide unit busy |
| busy_ls | input | 1 | Load/store unit busy |
| iss_sa_valid | output | 1 | Issue to simple unit A |
| iss_sa_tag | output | 6 | Tag issued to simple unit A |
| iss_sb_valid | output | 1 | Issue to simple unit B |
| iss_sb_tag | output | 6 | Tag issued to simple unit B |
| iss_md_valid | output | 1 | Issue to multiply/divide unit |
| iss_md_tag | output | 6 | Tag issued to multiply/divide unit |
| iss_ls_valid | output | 1 | Issue to load/store unit |
| iss_ls_tag | output | 6 | Tag issued to load/store unit |
| free_slots | output | 2 | Instructions accepted this cycle |

## Verification
A faulty compaction step shows up one cycle after the first issue. A wrong tag then appears at a port, or an instruction that should be at the bottom never issues. A stale ready flag, a wrong routing decision or a lost wake shows up in the same cycle the entry reaches the bottom two positions. It appears as a missing or extra issue valid. A miscount of occupancy appears at once on `free_slots`. A write accepted beyond capacity corrupts a held entry, and the damage appears as a wrong tag when the affected entry later issues.

// File: rtl/giq_pkg.sv
package giq_pkg;
   typedef enum logic [1:0] {
      CLS_FULL   = 2'd0,
      CLS_LITE   = 2'd1,
      CLS_MULDIV = 2'd2,
      CLS_LDST   = 2'd3
   } unit_cls_e;
endpackage

// File: rtl/giq_route.sv
// Port selection for the two issuing entries.
module giq_route #(
   parameter int TAG_W = 6
) (
   input  logic                  enable,
   input  logic [1:0]            e_valid,
   input  logic [1:0]            e_rdy,
   input  logic [1:0][1:0]       e_cls,
   input  logic [1:0][TAG_W-1:0] e_tag,
   input  logic                  busy_sa,
   input  logic                  busy_sb,
   input  logic                  busy_md,
   input  logic                  busy_ls,
   output logic [1:0]            take,
   output logic                  e0_md,
   output logic                  e0_ls,
   output logic                  sa_v,
   output logic [TAG_W-1:0]      sa_tag,
   output logic                  sb_v,
   output logic [TAG_W-1:0]      sb_tag,
   output logic                  md_v,
   output logic [TAG_W-1:0]      md_tag,
   output logic                  ls_v,
   output logic [TAG_W-1:0]      ls_tag
);
   import giq_pkg::*;

   logic can0, can1;
   logic e0_sa, e1_sb, e1_md, e1_ls;

   always_comb begin
      can0  = enable & e_valid[0] & e_rdy[0];
      can1  = enable & e_valid[1] & e_rdy[1];
      e0_sa = can0 & ((e_cls[0] == CLS_FULL) | (e_cls[0] == CLS_LITE)) & ~busy_sa;
      e0_md = can0 & (e_cls[0] == CLS_MULDIV) & ~busy_md;
      e0_ls = can0 & (e_cls[0] == CLS_LDST) & ~busy_ls;
      e1_sb = can1 & (e_cls[1] == CLS_LITE) & ~busy_sb;
      e1_md = can1 & (e_cls[1] == CLS_MULDIV) & ~busy_md & ~e0_md;
      e1_ls = can1 & (e_cls[1] == CLS_LDST) & ~busy_ls & ~e0_ls;
      take  = {e1_sb | e1_md | e1_ls, e0_sa | e0_md | e0_ls};
      sa_v  = e0_sa;
      sa_tag = e_tag[0];
      sb_v  = e1_sb;
      sb_tag = e_tag[1];
      md_v  = e0_md | e1_md;
      md_tag = e0_md ? e_tag[0] : e_tag[1];
      ls_v  = e0_ls | e1_ls;
      ls_tag = e0_ls ? e_tag[0] : e_tag[1];
   end
endmodule

// File: rtl/giq_compact.sv
// Next-state builder: wake, collapse of survivors, append of new lanes.
module giq_compact #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 6,
   parameter int WR    = 2,
   localparam int CAP_W = $clog2(WR + 1)
) (
   input  logic                      flush,
   input  logic [DEPTH-1:0]          cur_v,
   input  logic [DEPTH-1:0]          cur_rdy,
   input  logic [DEPTH-1:0][1:0]     cur_cls,
   input  logic [DEPTH-1:0][TAG_W-1:0] cur_tag,
   input  logic [1:0]                take,
   input  logic                      wake_valid,
   input  logic [TAG_W-1:0]          wake_tag,
   input  logic [WR-1:0]             in_valid,
   input  logic [WR-1:0][TAG_W-1:0]  in_tag,
   input  logic [WR-1:0][1:0]        in_cls,
   input  logic [WR-1:0]             in_rdy,
   output logic [DEPTH-1:0]          nxt_v,
   output logic [DEPTH-1:0]          nxt_rdy,
   output logic [DEPTH-1:0][1:0]     nxt_cls,
   output logic [DEPTH-1:0][TAG_W-1:0] nxt_tag,
   output logic [CAP_W-1:0]          cap
);
   logic [DEPTH-1:0] surv;
   logic [DEPTH-1:0] rdy_w;
   logic [WR-1:0]    in_rdy_w;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      if (i < 2) begin : g_issuing
         assign surv[i] = cur_v[i] & ~take[i];
      end else begin : g_waiting
         assign surv[i] = cur_v[i];
      end
      assign rdy_w[i] = cur_rdy[i] | (wake_valid & (cur_tag[i] == wake_tag));
   end

   for (genvar k = 0; k < WR; k++) begin : g_lane
      assign in_rdy_w[k] = in_rdy[k] | (wake_valid & (in_tag[k] == wake_tag));
   end

   always_comb begin
      int n;
      int acc;
      int room;
      n = 0;
      acc = 0;
      for (int i = 0; i < DEPTH; i++) n = n + int'(surv[i]);
      room = DEPTH - n;
      if (room > WR) room = WR;
      cap = CAP_W'(room);
      nxt_v   = '0;
      nxt_rdy = '0;
      nxt_cls = '0;
      nxt_tag = '0;
      n = 0;
      for (int i = 0; i < DEPTH; i++) begin
         if (surv[i]) begin
            nxt_v[n]   = 1'b1;
            nxt_rdy[n] = rdy_w[i];
            nxt_cls[n] = cur_cls[i];
            nxt_tag[n] = cur_tag[i];
            n = n + 1;
         end
      end
      for (int k = 0; k < WR; k++) begin
         if (in_valid[k] && acc < room && n < DEPTH) begin
            nxt_v[n]   = 1'b1;
            nxt_rdy[n] = in_rdy_w[k];
            nxt_cls[n] = in_cls[k];
            nxt_tag[n] = in_tag[k];
            n = n + 1;
            acc = acc + 1;
         end
      end
      if (flush) nxt_v = '0;
   end
endmodule

// File: rtl/gpr_issue_queue.sv
module gpr_issue_queue #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 6,
   parameter int WR    = 2,
   localparam int CAP_W = $clog2(WR + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [WR-1:0]            in_valid,
   input  logic [WR-1:0][TAG_W-1:0] in_tag,
   input  logic [WR-1:0][1:0]       in_cls,
   input  logic [WR-1:0]            in_rdy,
   input  logic                     wake_valid,
   input  logic [TAG_W-1:0]         wake_tag,
   input  logic                     busy_sa,
   input  logic                     busy_sb,
   input  logic                     busy_md,
   input  logic                     busy_ls,
   output logic                     iss_sa_valid,
   output logic [TAG_W-1:0]         iss_sa_tag,
   output logic                     iss_sb_valid,
   output logic [TAG_W-1:0]         iss_sb_tag,
   output logic                     iss_md_valid,
   output logic [TAG_W-1:0]         iss_md_tag,
   output logic                     iss_ls_valid,
   output logic [TAG_W-1:0]         iss_ls_tag,
   output logic [CAP_W-1:0]         free_slots
);
   import giq_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("issue queue needs at least two entries");
   end
   if (WR < 1 || WR > DEPTH) begin : g_bad_wr
      $error("write lanes must be between 1 and DEPTH");
   end

   logic [DEPTH-1:0]            q_v, q_rdy, n_v, n_rdy;
   logic [DEPTH-1:0][1:0]       q_cls, n_cls;
   logic [DEPTH-1:0][TAG_W-1:0] q_tag, n_tag;
   logic [1:0]                  take;
   logic                        e0_md, e0_ls;

   giq_route #(.TAG_W(TAG_W)) u_route (
      .enable (~flush),
      .e_valid(q_v[1:0]), .e_rdy(q_rdy[1:0]),
      .e_cls  (q_cls[1:0]), .e_tag(q_tag[1:0]),
      .busy_sa(busy_sa), .busy_sb(busy_sb), .busy_md(busy_md), .busy_ls(busy_ls),
      .take   (take), .e0_md(e0_md), .e0_ls(e0_ls),
      .sa_v(iss_sa_valid), .sa_tag(iss_sa_tag),
      .sb_v(iss_sb_valid), .sb_tag(iss_sb_tag),
      .md_v(iss_md_valid), .md_tag(iss_md_tag),
      .ls_v(iss_ls_valid), .ls_tag(iss_ls_tag)
   );

   giq_compact #(.DEPTH(DEPTH), .TAG_W(TAG_W), .WR(WR)) u_compact (
      .flush(flush),
      .cur_v(q_v), .cur_rdy(q_rdy), .cur_cls(q_cls), .cur_tag(q_tag),
      .take(take), .wake_valid(wake_valid), .wake_tag(wake_tag),
      .in_valid(in_valid), .in_tag(in_tag), .in_cls(in_cls), .in_rdy(in_rdy),
      .nxt_v(n_v), .nxt_rdy(n_rdy), .nxt_cls(n_cls), .nxt_tag(n_tag),
      .cap(free_slots)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_v   <= '0;
         q_rdy <= '0;
         q_cls <= '0;
         q_tag <= '0;
      end else begin
         q_v   <= n_v;
         q_rdy <= n_rdy;
         q_cls <= n_cls;
         q_tag <= n_tag;
      end
   end

   // Occupied entries always form a contiguous run from entry 0 (R8).
   p_packed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((q_v & (q_v + 1'b1)) == '0));

   // With no issue, write or flush, the held set stays put (R8).
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && in_valid == '0 && take == 2'b00) |=> $stable(q_v));

   p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (q_v == '0));

   p_flush_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !(iss_sa_valid || iss_sb_valid || iss_md_valid || iss_ls_valid));

   p_sb_lite_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_sb_valid |-> (q_v[1] && q_rdy[1] && q_cls[1] == 2'd1));

   p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !((busy_sa && iss_sa_valid) || (busy_sb && iss_sb_valid) ||
        (busy_md && iss_md_valid) || (busy_ls && iss_ls_valid)));

   p_e0_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (e0_md && take[1]) |-> (q_cls[1] != 2'd2));

   p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_v == '1 && take == 2'b00) |-> (free_slots == '0));
endmodule

// File: tb/gpr_issue_queue_test.sv
module gpr_issue_queue_test;
   logic clk = 0;
   logic rst_n = 0;
   logic flush = 0;
   logic [1:0] in_valid = 0;
   logic [1:0][5:0] in_tag = '0;
   logic [1:0][1:0] in_cls = '0;
   logic [1:0] in_rdy = 0;
   logic wake_valid = 0;
   logic [5:0] wake_tag = 0;
   logic busy_sa = 0, busy_sb = 0, busy_md = 0, busy_ls = 0;
   logic iss_sa_valid, iss_sb_valid, iss_md_valid, iss_ls_valid;
   logic [5:0] iss_sa_tag, iss_sb_tag, iss_md_tag, iss_ls_tag;
   logic [1:0] free_slots;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   gpr_issue_queue uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_tag(in_tag), .in_cls(in_cls), .in_rdy(in_rdy),
      .wake_valid(wake_valid), .wake_tag(wake_tag),
      .busy_sa(busy_sa), .busy_sb(busy_sb), .busy_md(busy_md), .busy_ls(busy_ls),
      .iss_sa_valid(iss_sa_valid), .iss_sa_tag(iss_sa_tag),
      .iss_sb_valid(iss_sb_valid), .iss_sb_tag(iss_sb_tag),
      .iss_md_valid(iss_md_valid), .iss_md_tag(iss_md_tag),
      .iss_ls_valid(iss_ls_valid), .iss_ls_tag(iss_ls_tag),
      .free_slots(free_slots)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(int lane, int tag, int cls, bit rdy);
      in_valid[lane] = 1'b1;
      in_tag[lane]   = 6'(tag);
      in_cls[lane]   = 2'(cls);
      in_rdy[lane]   = rdy;
   endtask

   task automatic wake(int tag);
      wake_valid = 1'b1;
      wake_tag   = 6'(tag);
   endtask

   // Commit one edge, return inputs to idle, let outputs settle.
   task automatic cyc();
      @(posedge clk);
      #1;
      in_valid = 0; wake_valid = 0; flush = 0;
      #1;
   endtask

   task automatic t_reset();
      chk("R1 sa valid", iss_sa_valid, 0);
      chk("R1 sb valid", iss_sb_valid, 0);
      chk("R1 md valid", iss_md_valid, 0);
      chk("R1 ls valid", iss_ls_valid, 0);
      chk("R1 free", free_slots, 2);
   endtask

   task automatic t_dual_issue();
      put(0, 1, 3, 1); put(1, 2, 1, 1);
      #1 chk("R2 not before edge", iss_ls_valid, 0);
      cyc();
      chk("R3 ls from e0", iss_ls_valid, 1);
      chk("R3 ls tag", iss_ls_tag, 1);
      chk("R4 sb from e1", iss_sb_valid, 1);
      chk("R4 sb tag", iss_sb_tag, 2);
      chk("R9 free after two issues", free_slots, 2);
      cyc();
      chk("R8 empty after issue", iss_ls_valid | iss_sb_valid, 0);
   endtask

   task automatic t_bypass();
      busy_md = 1;
      put(0, 3, 2, 1); put(1, 4, 3, 1);
      cyc();
      chk("R5 md blocked by busy", iss_md_valid, 0);
      chk("R6 e1 ls bypass", iss_ls_valid, 1);
      chk("R6 e1 ls tag", iss_ls_tag, 4);
      cyc();
      chk("R5 md still busy", iss_md_valid, 0);
      busy_md = 0;
      #1;
      chk("R3 md from e0", iss_md_valid, 1);
      chk("R3 md tag", iss_md_tag, 3);
      cyc();
   endtask

   task automatic t_full_class();
      put(0, 5, 0, 0); put(1, 6, 0, 1);
      cyc();
      chk("R5 unready e0", iss_sa_valid, 0);
      chk("R4 full never on sb", iss_sb_valid, 0);
      chk("R9 free two held", free_slots, 2);
      wake(5);
      cyc();
      chk("R10 wake held entry", iss_sa_valid, 1);
      chk("R3 sa tag", iss_sa_tag, 5);
      chk("R4 full e1 waits", iss_sb_valid, 0);
      cyc();
      chk("R8 e1 moved to e0", iss_sa_valid, 1);
      chk("R8 moved tag", iss_sa_tag, 6);
      cyc();
   endtask

   task automatic t_conflict();
      put(0, 7, 3, 1); put(1, 8, 3, 1);
      cyc();
      chk("R7 ls to e0", iss_ls_tag, 7);
      chk("R7 ls single", iss_ls_valid, 1);
      cyc();
      chk("R7 e1 next cycle", iss_ls_tag, 8);
      cyc();
      put(0, 9, 2, 1); put(1, 15, 2, 1);
      cyc();
      chk("R7 md to e0", iss_md_tag, 9);
      cyc();
      chk("R7 md e1 next", iss_md_tag, 15);
      cyc();
   endtask

   task automatic t_capacity();
      put(0, 10, 2, 0); put(1, 11, 3, 0);
      cyc();
      chk("R9 free half", free_slots, 2);
      put(0, 12, 1, 0); put(1, 13, 3, 0);
      cyc();
      chk("R9 free full", free_slots, 0);
      put(0, 14, 3, 1);
      cyc();
      chk("R9 dropped write no issue", iss_ls_valid, 0);
      chk("R9 still full", free_slots, 0);
      wake(11);
      cyc();
      chk("R10 e1 ls wake", iss_ls_valid, 1);
      chk("R10 e1 ls tag", iss_ls_tag, 11);
      chk("R9 free one", free_slots, 1);
      cyc();
      wake(13);
      cyc();
      chk("R5 e2 ready stays", iss_ls_valid, 0);
      wake(10);
      cyc();
      chk("R3 md wake e0", iss_md_tag, 10);
      chk("R3 md wake valid", iss_md_valid, 1);
      cyc();
      chk("R8 order kept e1", iss_ls_tag, 13);
      chk("R8 order e1 valid", iss_ls_valid, 1);
      chk("R5 lite e0 not ready", iss_sa_valid, 0);
   endtask

   task automatic t_flush();
      flush = 1;
      put(0, 20, 3, 1);
      #1;
      chk("R11 issue suppressed", iss_ls_valid, 0);
      cyc();
      chk("R11 empty free", free_slots, 2);
      chk("R11 write dropped", iss_ls_valid, 0);
      chk("R11 no sa", iss_sa_valid, 0);
   endtask

   task automatic t_wake_incoming();
      put(0, 24, 3, 0);
      wake(24);
      cyc();
      chk("R10 incoming woken", iss_ls_valid, 1);
      chk("R10 incoming tag", iss_ls_tag, 24);
      cyc();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      t_reset();
      t_dual_issue();
      t_bypass();
      t_full_class();
      t_conflict();
      t_capacity();
      t_flush();
      t_wake_incoming();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule